// File: doc/BRIEF.md
# Serial DAC Reference Control Receiver

This block is the slave-side command receiver for a single-channel digital-to-analog converter. A host frames each write by pulling an active-low frame select low. It then clocks data in, most significant bit first, and the receiver samples each bit on a falling serial clock edge. The receiver runs on a fast system clock. It synchronises the three serial pins, detects their edges, and judges each frame in the cycle after the frame select rises.

Ordinary data writes load a 16-bit converter code. Reference commands switch an internal voltage reference off or back on. Such a command only counts when the host keeps clocking for at least two extra falling edges past the 24-bit word. Switching the reference off takes one such frame. Switching it back on takes two distinct frames in a fixed order, or a reset. While the reference is off, the reference pin driver is released and the converter code keeps updating from writes.

The frame state machine has three states. `FR_IDLE` goes to `FR_SHIFT` when the frame select falls. `FR_SHIFT` goes to `FR_DECIDE` when the frame select rises. `FR_DECIDE` always returns to `FR_IDLE` after one cycle, and that is when actions are taken.

The reference state machine also has three states: `RF_ON`, `RF_OFF` and `RF_OFF_ARMED`. Its transitions are taken only in `FR_DECIDE` for frames of at least 24 bits:
- `RF_ON` to `RF_OFF` on a qualified off command.
- `RF_OFF` to `RF_OFF_ARMED` on a qualified step-one command.
- `RF_OFF_ARMED` to `RF_ON` on a qualified step-two command.
- `RF_OFF_ARMED` stays in `RF_OFF_ARMED` on another qualified step-one command.
- `RF_OFF_ARMED` to `RF_OFF` on any other completed frame.

Top module: `dac_serial_ref_rx`

## Requirements
- R1: After reset the code output is 0, the reference enable and pin enable are both 1, and the load pulse is 0.
- R2: A frame of 24 or more falling edges whose bits 23:16 equal 0x00 loads bits 15:0 into the code output when the frame select rises. Bits are taken MSB first, and bits after the 24th are ignored.
- R3: A frame that ends before 24 falling edges changes no output.
- R4: A qualified frame (26 or more falling edges) with command byte 0x90 and word 0x0001 drives the reference enable and pin enable to 0.
- R5: A command-0x90 frame that ends with 24 or 25 edges leaves the reference state unchanged and does not load the code.
- R6: Reference enable returns to 1 after a qualified 0x90/0x0002 frame followed directly by a qualified 0x90/0x0003 frame.
- R7: A 0x90/0x0003 frame without a 0x90/0x0002 frame directly before it is ignored. Any other completed frame between the two cancels the pending first step.
- R8: Data writes keep loading the code while the reference is off.
- R9: Reset restores the reference to enabled from the off state.
- R10: Every code load is marked by a load pulse of exactly one system clock. Command bytes other than 0x00 never load the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, bits sampled on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Latched converter code |
| dac_load | output | 1 | One-cycle pulse when the code is loaded |
| ref_en | output | 1 | Internal reference enabled |
| ref_pin_oe | output | 1 | Reference pin driver enable (0 = high impedance) |

## Verification
The bench sends reference frames of 24 and 25 edges. A design that qualified on the word length alone would turn the reference off, or back on, too early. It sends step two on its own, and step one then a data write then step two. A design that kept a stale armed flag would re-enable the reference. It also cuts frames short and pads data frames past 24 bits. These cases catch a receiver that loads partial words or shifts the padding into the code. Random frames from a fixed seed mix all command kinds and lengths against a bench model of the reference state.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SHIFT  = 2'd1,
        FR_DECIDE = 2'd2
    } frame_st_t;

    typedef enum logic [1:0] {
        RF_ON        = 2'd0,
        RF_OFF       = 2'd1,
        RF_OFF_ARMED = 2'd2
    } ref_st_t;
endpackage

// File: rtl/sdr_pin_sync.sv
module sdr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sync_n_i,
    input  logic sdin_i,
    output logic sclk_fall,
    output logic sync_fall,
    output logic sync_rise,
    output logic sync_low,
    output logic sdin_s
);
    logic [STAGES-1:0] sclk_q, sync_q, din_q;
    logic              sclk_d, sync_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '1;
            sync_q <= '1;
            din_q  <= '0;
            sclk_d <= 1'b1;
            sync_d <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
            sync_q <= {sync_q[STAGES-2:0], sync_n_i};
            din_q  <= {din_q[STAGES-2:0], sdin_i};
            sclk_d <= sclk_q[STAGES-1];
            sync_d <= sync_q[STAGES-1];
        end
    end

    assign sclk_fall = sclk_d & ~sclk_q[STAGES-1];
    assign sync_fall = sync_d & ~sync_q[STAGES-1];
    assign sync_rise = ~sync_d & sync_q[STAGES-1];
    assign sync_low  = ~sync_q[STAGES-1];
    assign sdin_s    = din_q[STAGES-1];
endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
    parameter int FRAME_BITS = 24,
    parameter int QUAL_BITS  = 26,
    localparam int CNT_W     = $clog2(QUAL_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  bit_stb,
    input  logic                  bit_i,
    output logic [FRAME_BITS-1:0] word,
    output logic [CNT_W-1:0]      bit_cnt
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(QUAL_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (start) begin
            bit_cnt <= '0;
        end else if (bit_stb) begin
            if (bit_cnt < FULL_C)
                word <= {word[FRAME_BITS-2:0], bit_i};
            if (bit_cnt < SAT_C)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dac_serial_ref_rx.sv
module dac_serial_ref_rx #(
    parameter int              DATA_W      = 16,
    parameter int              CMD_W       = 8,
    parameter int              EXTRA_CLKS  = 2,
    parameter int              SYNC_STAGES = 2,
    parameter logic [7:0]      CMD_WRITE   = 8'h00,
    parameter logic [7:0]      CMD_REF     = 8'h90,
    parameter logic [15:0]     WORD_OFF    = 16'h0001,
    parameter logic [15:0]     WORD_ON1    = 16'h0002,
    parameter logic [15:0]     WORD_ON2    = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdin,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_load,
    output logic              ref_en,
    output logic              ref_pin_oe
);
    import sdr_pkg::*;

    localparam int FRAME_BITS = CMD_W + DATA_W;
    localparam int QUAL_BITS  = FRAME_BITS + EXTRA_CLKS;
    localparam int CNT_W      = $clog2(QUAL_BITS + 1);

    logic                  sclk_fall, sync_fall, sync_rise, sync_low, sdin_s;
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      bit_cnt;
    frame_st_t             fr_st, fr_nxt;
    ref_st_t               rf_st, rf_nxt;
    logic                  full, qual, is_wr, is_ref, deciding;
    logic [CMD_W-1:0]      cmd;
    logic [DATA_W-1:0]     dat;

    sdr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
        .sclk_fall(sclk_fall), .sync_fall(sync_fall), .sync_rise(sync_rise),
        .sync_low(sync_low), .sdin_s(sdin_s)
    );

    sdr_shifter #(.FRAME_BITS(FRAME_BITS), .QUAL_BITS(QUAL_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sync_fall),
        .bit_stb(sclk_fall & sync_low), .bit_i(sdin_s),
        .word(word), .bit_cnt(bit_cnt)
    );

    assign cmd      = word[FRAME_BITS-1 -: CMD_W];
    assign dat      = word[DATA_W-1:0];
    assign full     = bit_cnt >= CNT_W'(FRAME_BITS);
    assign qual     = bit_cnt >= CNT_W'(QUAL_BITS);
    assign is_wr    = full && (cmd == CMD_W'(CMD_WRITE));
    assign is_ref   = qual && (cmd == CMD_W'(CMD_REF));
    assign deciding = (fr_st == FR_DECIDE);

    always_comb begin
        fr_nxt = fr_st;
        unique case (fr_st)
            FR_IDLE:   if (sync_fall) fr_nxt = FR_SHIFT;
            FR_SHIFT:  if (sync_rise) fr_nxt = FR_DECIDE;
            FR_DECIDE: fr_nxt = FR_IDLE;
            default:   fr_nxt = FR_IDLE;
        endcase
    end

    always_comb begin
        rf_nxt = rf_st;
        if (deciding && full) begin
            unique case (rf_st)
                RF_ON:
                    if (is_ref && dat == DATA_W'(WORD_OFF)) rf_nxt = RF_OFF;
                RF_OFF:
                    if (is_ref && dat == DATA_W'(WORD_ON1)) rf_nxt = RF_OFF_ARMED;
                RF_OFF_ARMED:
                    if (is_ref && dat == DATA_W'(WORD_ON2))      rf_nxt = RF_ON;
                    else if (is_ref && dat == DATA_W'(WORD_ON1)) rf_nxt = RF_OFF_ARMED;
                    else                                         rf_nxt = RF_OFF;
                default: rf_nxt = RF_ON;
            endcase
        end
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_st <= FR_IDLE;
            rf_st <= RF_ON;
        end else begin
            fr_st <= fr_nxt;
            rf_st <= rf_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code   <= '0;
            dac_load   <= 1'b0;
            ref_en     <= 1'b1;
            ref_pin_oe <= 1'b1;
        end else begin
            dac_load   <= deciding && is_wr;
            if (deciding && is_wr)
                dac_code <= dat;
            ref_en     <= (rf_nxt == RF_ON);
            ref_pin_oe <= (rf_nxt == RF_ON);
        end
    end

    a_r10_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);
    a_r2_code_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> dac_load);
    a_r3_short_frame_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (deciding && bit_cnt < CNT_W'(FRAME_BITS)) |=> (!dac_load && $stable(dac_code)));
    a_r5_unqualified_ref_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (deciding && bit_cnt < CNT_W'(QUAL_BITS)) |=> $stable(ref_en));
    a_r4_off_at_decide: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_en) |-> $past(fr_st == FR_DECIDE));
    a_r6_on_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en) |-> $past(rf_st == RF_OFF_ARMED));
endmodule

// File: tb/tb_dac_serial_ref_rx.sv
module tb_dac_serial_ref_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        sdin = 1'b0;
    logic [15:0] dac_code;
    logic        dac_load;
    logic        ref_en;
    logic        ref_pin_oe;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    int load_mark = 0;
    bit done = 0;

    logic [15:0] m_code;
    int          m_ref;   // 0 on, 1 off, 2 off and armed
    int          m_loads;

    always #2 clk = ~clk;

    dac_serial_ref_rx dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .dac_code(dac_code), .dac_load(dac_load), .ref_en(ref_en), .ref_pin_oe(ref_pin_oe)
    );

    always @(posedge clk) if (rst_n && dac_load) loads <= loads + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int next_ref(input int st, input logic [23:0] w, input int n);
        bit q;
        q = (n >= 26) && (w[23:16] == 8'h90);
        if (n < 24) return st;
        case (st)
            0: return (q && w[15:0] == 16'h0001) ? 1 : 0;
            1: return (q && w[15:0] == 16'h0002) ? 2 : 1;
            default: return (q && w[15:0] == 16'h0003) ? 0 :
                            (q && w[15:0] == 16'h0002) ? 2 : 1;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        m_code = '0; m_ref = 0; m_loads = 0;
        load_mark = loads;
    endtask

    task automatic frame(input logic [23:0] w, input int n);
        load_mark = loads;
        @(negedge clk);
        sync_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdin = (i < 24) ? w[23-i] : 1'($urandom);
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (4) @(negedge clk);
        sync_n = 1'b1;
        repeat (12) @(negedge clk);
        m_loads = 0;
        if (n >= 24 && w[23:16] == 8'h00) begin
            m_code = w[15:0];
            m_loads = 1;
        end
        m_ref = next_ref(m_ref, w, n);
    endtask

    task automatic check_all(input string req);
        chk({req, " code"}, 32'(dac_code), 32'(m_code));
        chk({req, " ref_en"}, 32'(ref_en), 32'(m_ref == 0));
        chk({req, " pin_oe"}, 32'(ref_pin_oe), 32'(m_ref == 0));
        chk({req, " loads"}, 32'(loads - load_mark), 32'(m_loads));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R1 code", 32'(dac_code), 0);
        chk("R1 ref_en", 32'(ref_en), 1);
        chk("R1 pin_oe", 32'(ref_pin_oe), 1);
        chk("R1 load", 32'(dac_load), 0);

        frame(24'h00_A5C3, 24); check_all("R2 write 24");
        frame(24'h00_1234, 31); check_all("R2 write padded");
        frame(24'h00_FFFF, 20); check_all("R3 short write");
        frame(24'h90_0001, 25); check_all("R5 off with 25");
        frame(24'h90_0001, 24); check_all("R5 off with 24");
        frame(24'h90_0001, 26); check_all("R4 off qualified");
        frame(24'h00_0F0F, 24); check_all("R8 write while off");
        frame(24'h90_0003, 26); check_all("R7 step2 alone");
        frame(24'h90_0002, 26); check_all("R7 step1");
        frame(24'h00_7777, 24); check_all("R7 intervening write");
        frame(24'h90_0003, 26); check_all("R7 step2 after cancel");
        frame(24'h90_0002, 26);
        frame(24'h90_0003, 25); check_all("R5 step2 short");
        frame(24'h90_0002, 26);
        frame(24'h90_0003, 27); check_all("R6 re-enable");
        frame(24'h55_BEEF, 26); check_all("R10 other command");
        frame(24'h90_0001, 28); check_all("R4 off again");
        do_reset();
        chk("R9 ref_en after reset", 32'(ref_en), 1);
        chk("R9 pin_oe after reset", 32'(ref_pin_oe), 1);

        for (int k = 0; k < 200; k++) begin
            logic [23:0] w;
            int n;
            int lens[5] = '{20, 24, 25, 26, 28};
            case ($urandom_range(0, 3))
                0: w = {8'h00, 16'($urandom)};
                1: w = {8'h90, 16'($urandom_range(1, 3))};
                2: w = {8'h90, 16'($urandom_range(1, 3))};
                default: w = 24'($urandom);
            endcase
            n = lens[$urandom_range(0, 4)];
            frame(w, n);
            check_all("R2 R6 R7 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule